// File: doc/BRIEF.md
# Clock liveness monitor

This block watches a critical clock or toggling signal and checks that it is still running at a plausible rate. Its timebase is a free-running reference oscillator of about 50 MHz, which the user logic cannot stop. The block brings the monitored input into the reference domain and counts its rising edges over a fixed gate of reference cycles. At the end of each gate it checks the count against a programmable lower and upper bound. A signal that has stalled produces a count of zero, and a zero count always fails. No edges are needed to detect a stall.

The reference itself may run anywhere from half to one and a half times its nominal rate, or slightly wider. A slow reference lengthens the gate and raises the count, and a fast reference shortens the gate and lowers it. The bound inputs therefore have to be set wide enough to cover both cases. The monitor rejects isolated glitches by raising its alarm only after a programmable number of failing gates in a row. Once raised, the alarm stays high until reset, so a tamper controller can act on it and impose a penalty.

Top module: `clk_liveness_mon`

## Requirements
- R1: The monitored input passes through a two-flop synchronizer in the reference domain. Rising edges of the synchronized signal are counted over a gate of GATE_LEN reference cycles. A periodic input with period P reference cycles, where P divides GATE_LEN, gives a count of GATE_LEN/P.
- R2: The edge count saturates at 2^CNT_W-1 and does not wrap.
- R3: At each gate end, cnt_o is loaded with the gate's count and cnt_vld_o pulses high for exactly one cycle. The first gate after reset is discarded, so the first pulse follows the 2*GATE_LEN-th reference edge after reset release.
- R4: A gate passes only when min_cnt_i <= count <= max_cnt_i, with both bounds inclusive.
- R5: A count of zero always fails, even when min_cnt_i is 0.
- R6: alarm_o rises with the cnt_vld_o pulse of the fail_lim_i-th failing gate in a row. Any passing gate resets the run of failures.
- R7: A fail_lim_i of 0 behaves like 1.
- R8: Once alarm_o is high, it stays high until reset, whatever later gates report.
- R9: While rst_ni is low, cnt_o, cnt_vld_o and alarm_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mon_i | input | 1 | Monitored clock or signal, asynchronous |
| min_cnt_i | input | CNT_W | Lowest passing edge count per gate |
| max_cnt_i | input | CNT_W | Highest passing edge count per gate |
| fail_lim_i | input | FAIL_W | Consecutive failing gates needed to raise the alarm |
| cnt_o | output | CNT_W | Edge count of the most recent gate |
| cnt_vld_o | output | 1 | One-cycle strobe marking a new cnt_o |
| alarm_o | output | 1 | Sticky out-of-range alarm |

## Verification
cnt_o, cnt_vld_o and alarm_o all change on the reference edge that closes a gate. The first such edge after reset is edge 2*GATE_LEN. The bench counts falling edges from reset release to that strobe and samples every result at the falling edge where cnt_vld_o is high. Because of the synchronizer, an input change reaches the counter two to three cycles late, so the gate in which the input changes holds a mix of the old and new patterns. Exact counts are checked only on gates whose whole window saw one steady pattern, namely the pattern applied during reset. The consecutive-failure tests change the input just after a strobe and use bounds chosen so that the mixed gate passes or fails unambiguously.

// File: rtl/clm_pkg.sv
package clm_pkg;
  localparam int unsigned MIN_GATE_LEN = 2;
  localparam int unsigned SYNC_STAGES  = 2;
endpackage

// File: rtl/clm_sync_edge.sv
module clm_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [clm_pkg::SYNC_STAGES-1:0] sync_q;
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[clm_pkg::SYNC_STAGES-2:0], async_i};
      prev_q <= sync_q[clm_pkg::SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[clm_pkg::SYNC_STAGES-1] & ~prev_q;

  AST_RISE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R1
endmodule

// File: rtl/clm_gate_timer.sv
module clm_gate_timer #(
  parameter int unsigned GATE_LEN = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic last_o,
  output logic gate_done_o
);
  localparam int unsigned GATE_W = (GATE_LEN > 2) ? $clog2(GATE_LEN) : 1;
  localparam logic [GATE_W-1:0] GATE_END = GATE_W'(GATE_LEN - 1);

  logic [GATE_W-1:0] gate_q;
  logic first_q;

  assign last_o      = (gate_q == GATE_END);
  assign gate_done_o = last_o & ~first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= '0;
      first_q <= 1'b1;
    end else begin
      gate_q <= last_o ? '0 : gate_q + 1'b1;
      if (last_o) first_q <= 1'b0;
    end
  end

  AST_DONE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_done_o |=> !gate_done_o); // R3
  AST_FIRST_SKIPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_q && last_o) |-> !gate_done_o); // R3
endmodule

// File: rtl/clm_edge_counter.sv
module clm_edge_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             last_i,
  output logic [CNT_W-1:0] sample_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  // the edge seen in the closing cycle still belongs to the closing gate
  assign sample_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (last_i) cnt_q <= '0;
    else             cnt_q <= sample_o;
  end

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !last_i) |=> cnt_q == CNT_MAX); // R2
endmodule

// File: rtl/clm_judge.sv
module clm_judge #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned FAIL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_done_i,
  input  logic [CNT_W-1:0]  sample_i,
  input  logic [CNT_W-1:0]  min_cnt_i,
  input  logic [CNT_W-1:0]  max_cnt_i,
  input  logic [FAIL_W-1:0] fail_lim_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_vld_o,
  output logic              alarm_o
);
  localparam logic [FAIL_W-1:0] RUN_MAX = '1;

  logic [FAIL_W-1:0] run_q, run_nxt, lim_eff;
  logic fail, trip;

  assign fail    = (sample_i == '0) || (sample_i < min_cnt_i) || (sample_i > max_cnt_i);
  assign lim_eff = (fail_lim_i == '0) ? FAIL_W'(1) : fail_lim_i;
  assign run_nxt = !fail ? '0 : (run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1;
  assign trip    = gate_done_i && fail && (run_nxt >= lim_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      cnt_o     <= '0;
      cnt_vld_o <= 1'b0;
      alarm_o   <= 1'b0;
    end else begin
      cnt_vld_o <= gate_done_i;
      if (gate_done_i) begin
        cnt_o <= sample_i;
        run_q <= run_nxt;
      end
      if (trip) alarm_o <= 1'b1;
    end
  end

  AST_ZERO_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_done_i && sample_i == '0) |=> run_q != '0); // R5
  AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |=> alarm_o); // R8
  AST_ALARM_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> cnt_vld_o); // R6
  AST_PASS_CLEARS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_done_i && sample_i != '0 && sample_i >= min_cnt_i && sample_i <= max_cnt_i)
      |=> run_q == '0); // R6
endmodule

// File: rtl/clk_liveness_mon.sv
module clk_liveness_mon #(
  parameter int unsigned GATE_LEN = 1024,
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned FAIL_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mon_i,
  input  logic [CNT_W-1:0]  min_cnt_i,
  input  logic [CNT_W-1:0]  max_cnt_i,
  input  logic [FAIL_W-1:0] fail_lim_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_vld_o,
  output logic              alarm_o
);
  logic rise, last, gate_done;
  logic [CNT_W-1:0] sample;

  clm_sync_edge u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (mon_i),
    .rise_o  (rise)
  );

  clm_gate_timer #(.GATE_LEN(GATE_LEN)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .last_o      (last),
    .gate_done_o (gate_done)
  );

  clm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .last_i   (last),
    .sample_o (sample)
  );

  clm_judge #(.CNT_W(CNT_W), .FAIL_W(FAIL_W)) u_judge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gate_done_i (gate_done),
    .sample_i    (sample),
    .min_cnt_i   (min_cnt_i),
    .max_cnt_i   (max_cnt_i),
    .fail_lim_i  (fail_lim_i),
    .cnt_o       (cnt_o),
    .cnt_vld_o   (cnt_vld_o),
    .alarm_o     (alarm_o)
  );

  initial begin
    AST_GATE_PARAM: assert (GATE_LEN >= clm_pkg::MIN_GATE_LEN); // R3
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!cnt_vld_o && !alarm_o && cnt_o == '0)); // R9
endmodule

// File: tb/sim_clk_liveness_mon.sv
module sim_clk_liveness_mon;
  localparam int G  = 32;
  localparam int CW = 4;
  localparam int FW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mon_i = 1'b0;
  logic [CW-1:0] min_cnt_i = '0, max_cnt_i = '1;
  logic [FW-1:0] fail_lim_i = FW'(1);
  logic [CW-1:0] cnt_o;
  logic cnt_vld_o, alarm_o;

  int total = 0, bad = 0;
  int per = 0, ph = 0;

  always #2 clk_i = ~clk_i;

  clk_liveness_mon #(.GATE_LEN(G), .CNT_W(CW), .FAIL_W(FW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mon_i(mon_i),
    .min_cnt_i(min_cnt_i), .max_cnt_i(max_cnt_i), .fail_lim_i(fail_lim_i),
    .cnt_o(cnt_o), .cnt_vld_o(cnt_vld_o), .alarm_o(alarm_o)
  );

  // stimulus pattern: period per reference cycles, 0 = stalled low
  always @(negedge clk_i) begin
    if (per == 0) begin
      mon_i = 1'b0;
      ph = 0;
    end else begin
      mon_i = (ph < per / 2);
      ph = (ph + 1) % per;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_vld();
    do @(negedge clk_i); while (!cnt_vld_o);
  endtask

  // reset with settings, release, return cycles to the first strobe
  task automatic restart(input int p, input int mn, input int mx, input int k, output int n);
    @(negedge clk_i);
    rst_ni = 1'b0;
    per = p;
    min_cnt_i = CW'(mn);
    max_cnt_i = CW'(mx);
    fail_lim_i = FW'(k);
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!cnt_vld_o && n < 4 * G);
  endtask

  // period, min, max, limit, expected count, expected alarm
  localparam int NV = 11;
  localparam int VEC [NV][6] = '{
    '{ 4, 4, 12, 1,  8, 0},   // R1 R4 inside
    '{ 8, 4, 12, 1,  4, 0},   // R4 at lower bound
    '{16, 4, 12, 1,  2, 1},   // R4 below
    '{ 2, 4, 12, 1, 15, 1},   // R2 saturated, above
    '{ 2, 4, 15, 1, 15, 0},   // R2 R4 at upper bound
    '{ 0, 0, 15, 1,  0, 1},   // R5 stall with min 0
    '{32, 1,  1, 1,  1, 0},   // R1 one edge
    '{ 8, 5, 12, 1,  4, 1},   // R4 just below
    '{ 0, 0, 15, 0,  0, 1},   // R7 limit 0 acts as 1
    '{16, 4, 12, 2,  2, 0},   // R6 first failure of two
    '{ 4, 9, 12, 1,  8, 1}    // R4 below again
  };

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    // R9 reset state
    repeat (3) @(negedge clk_i);
    check("R9 cnt in reset", cnt_o, 0);
    check("R9 vld in reset", cnt_vld_o, 0);
    check("R9 alarm in reset", alarm_o, 0);

    for (int i = 0; i < NV; i++) begin
      restart(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], n);
      check($sformatf("R3 first strobe delay v%0d", i), n, 2 * G);
      check($sformatf("R1 R2 count v%0d", i), cnt_o, VEC[i][4]);
      check($sformatf("R4 R5 alarm v%0d", i), alarm_o, VEC[i][5]);
      @(negedge clk_i);
      check($sformatf("R3 strobe one cycle v%0d", i), cnt_vld_o, 0);
    end

    // R6 three consecutive failures
    restart(4, 4, 12, 3, n);
    check("R6 pass gate", alarm_o, 0);
    per = 0;
    wait_vld(); check("R6 fail 1", alarm_o, 0);
    wait_vld(); check("R6 fail 2", alarm_o, 0);
    wait_vld(); check("R6 fail 3 trips", alarm_o, 1);
    // R8 sticky
    per = 4;
    repeat (3) wait_vld();
    check("R8 stays after recovery", alarm_o, 1);
    check("R8 recovered count", cnt_o, 8);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9 R8 reset clears alarm", alarm_o, 0);

    // R6 passing gate breaks the run
    restart(4, 4, 12, 3, n);
    per = 0;
    repeat (2) wait_vld();
    per = 4;
    wait_vld();
    per = 0;
    repeat (2) wait_vld();
    check("R6 run reset by pass", alarm_o, 0);
    wait_vld();
    check("R6 third in new run", alarm_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule